// File: doc/BRIEF.md
# Dual Warp Issue Stage

This block is the issue stage of a simplified SIMT multiprocessor. It keeps a ready flag for each of eight resident warp slots. Each slot also shows the class of its pending instruction on an input bus. Two schedulers run side by side. One owns the even slots and the other owns the odd slots, so they can never choose the same warp. In each cycle, each scheduler may launch one ready warp onto one of three execution groups: a 16-lane arithmetic core group, a 16-lane load/store group, or a 4-lane special-function group.

A 32-thread warp does not fit a 16-lane group in one cycle. It is sent as two beats on back-to-back cycles: the first beat carries threads 0-15 and the second carries threads 16-31. On the 4-lane group the same warp takes eight beats. A group accepts a new warp only when it is idle or showing its final beat.

A warp that is waiting on a long memory access is taken out of selection with its stall bit. A wake pulse brings it back. The schedulers simply pass over stalled warps and warps whose group is busy. Round-robin selection inside each scheduler keeps every slot served.

Top module: `warp_issue`

## Requirements
- R1: After reset every ready flag is clear and every `dsp_vld` bit stays 0 until some warp is woken, whatever `cls` holds.
- R2: A `wake` bit sampled at clock edge k marks the slot ready. If its group is free, beat 0 of that warp appears on the outputs right after edge k+1.
- R3: Class code 0 selects group 0 (arithmetic) and class code 1 selects group 1 (load/store). Each such warp occupies its group for exactly two consecutive cycles, beat 0 then beat 1, with the same warp id and lane mask 16'hFFFF.
- R4: Class code 2 selects group 2 (special function). The warp is sent as beats 0 through 7 on eight consecutive cycles with lane mask 16'h000F.
- R5: Issuing a warp clears its ready flag, so one wake gives exactly one issue. A wake in the same cycle as the issue keeps the warp ready.
- R6: A `stall` bit clears the slot's ready flag from the next edge, and it takes priority over a `wake` bit in the same cycle. A stalled warp is never issued until it is woken again.
- R7: Scheduler 0 serves even slots and scheduler 1 serves odd slots. When their warps target different free groups, both warps start beat 0 in the same cycle.
- R8: When both schedulers want the same free group in the same cycle, the even warp wins. The odd warp starts beat 0 in the cycle after the winner's last beat.
- R9: A ready warp whose group is busy is skipped. Another ready warp of the same scheduler whose group is free is issued instead.
- R10: Among its ready and eligible warps, each scheduler picks the first one found in slot order, starting just after the last warp it issued and wrapping around. After reset the search starts at its lowest slot.
- R11: Class code 3 marks a warp as not issuable. Such a warp stays ready, and it issues once its class changes to a valid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wake | input | 8 | One bit per slot: set ready |
| stall | input | 8 | One bit per slot: clear ready (wins over wake) |
| cls | input | 16 | Pending class per slot, 2 bits at [2*w+:2] |
| dsp_vld | output | 3 | Beat valid per group (0 core, 1 load/store, 2 special) |
| dsp_wid | output | 9 | Warp id per group, 3 bits at [3*g+:3] |
| dsp_beat | output | 9 | Beat index per group, 3 bits at [3*g+:3] |
| dsp_mask | output | 48 | Lane-active mask per group, 16 bits at [16*g+:16] |

## Verification
There are two register stages between an input and the outputs. A wake is captured into the ready flags at one edge, and the selection made from those flags loads the group registers at the next edge. So beat 0 is due two edges after the wake is driven, and every later beat follows one edge apart. A class change on an already-ready warp shows up one edge later. The bench drives inputs on falling edges, counts falling edges from each stimulus, and compares the group outputs at exactly the count where each beat is due. It also checks the idle cycle after the last beat, which shows that nothing issues a second time.

// File: rtl/warp_issue.sv
module warp_issue #(
  parameter int NW = 8,
  parameter int WARP = 32,
  parameter int CLANES = 16,
  parameter int SLANES = 4,
  localparam int IW = $clog2(NW),
  localparam int BW = $clog2(WARP / SLANES),
  localparam int NG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NW-1:0]        wake,
  input  logic [NW-1:0]        stall,
  input  logic [2*NW-1:0]      cls,
  output logic [NG-1:0]        dsp_vld,
  output logic [NG*IW-1:0]     dsp_wid,
  output logic [NG*BW-1:0]     dsp_beat,
  output logic [NG*CLANES-1:0] dsp_mask
);
  localparam int NH = NW / 2;
  localparam int HW = $clog2(NH);

  function automatic int nbeats(int g);
    return (g == 2) ? WARP / SLANES : WARP / CLANES;
  endfunction

  logic [NW-1:0] ready, iss;
  logic [HW-1:0] ptr [2];
  logic [HW-1:0] sel [2];
  logic [1:0]    scls [2];
  logic [1:0]    hit, go;
  logic [3:0]    free;
  logic [NG-1:0] act;
  logic [IW-1:0] wid [NG];
  logic [BW-1:0] beat [NG];

  assign free[3] = 1'b0;

  always_comb begin
    int slot;
    logic [HW-1:0] li;
    logic [1:0] c;
    slot = 0;
    li = '0;
    c = '0;
    for (int s = 0; s < 2; s++) begin
      hit[s] = 1'b0;
      sel[s] = '0;
      scls[s] = '0;
      for (int k = 0; k < NH; k++) begin
        li = ptr[s] + HW'(k);
        slot = 2 * int'(li) + s;
        c = cls[2*slot +: 2];
        if (!hit[s] && ready[slot] && free[c]) begin
          hit[s] = 1'b1;
          sel[s] = li;
          scls[s] = c;
        end
      end
    end
    go[0] = hit[0];
    go[1] = hit[1] && !(hit[0] && scls[0] == scls[1]);
    iss = '0;
    if (go[0]) iss[{sel[0], 1'b0}] = 1'b1;
    if (go[1]) iss[{sel[1], 1'b1}] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= '0;
      ptr[0] <= '0;
      ptr[1] <= '0;
    end else begin
      ready <= ((ready & ~iss) | wake) & ~stall;
      for (int s = 0; s < 2; s++)
        if (go[s]) ptr[s] <= sel[s] + 1'b1;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam logic [BW-1:0] LAST = BW'(nbeats(g) - 1);
    localparam int LN = (g == 2) ? SLANES : CLANES;

    assign free[g] = !act[g] || beat[g] == LAST;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act[g]  <= 1'b0;
        wid[g]  <= '0;
        beat[g] <= '0;
      end else if (go[0] && scls[0] == 2'(g)) begin
        act[g]  <= 1'b1;
        wid[g]  <= {sel[0], 1'b0};
        beat[g] <= '0;
      end else if (go[1] && scls[1] == 2'(g)) begin
        act[g]  <= 1'b1;
        wid[g]  <= {sel[1], 1'b1};
        beat[g] <= '0;
      end else if (act[g] && beat[g] == LAST) begin
        act[g]  <= 1'b0;
      end else if (act[g]) begin
        beat[g] <= beat[g] + 1'b1;
      end
    end

    assign dsp_vld[g]                 = act[g];
    assign dsp_wid[g*IW +: IW]        = wid[g];
    assign dsp_beat[g*BW +: BW]       = beat[g];
    assign dsp_mask[g*CLANES +: CLANES] =
      act[g] ? CLANES'((1 << LN) - 1) : '0;
  end
endmodule

// File: rtl/warp_issue_chk.sv
module warp_issue_chk #(
  parameter int NW = 8,
  parameter int IW = 3,
  parameter int BW = 3,
  parameter int CB = 2,
  parameter int SB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      dsp_vld,
  input logic [3*IW-1:0] dsp_wid,
  input logic [3*BW-1:0] dsp_beat,
  input logic [NW-1:0]   ready
);
  logic [IW-1:0] w0, w1, w2;
  logic [BW-1:0] b0, b1, b2;
  logic [NW-1:0] ready_q;

  assign w0 = dsp_wid[0 +: IW];
  assign w1 = dsp_wid[IW +: IW];
  assign w2 = dsp_wid[2*IW +: IW];
  assign b0 = dsp_beat[0 +: BW];
  assign b1 = dsp_beat[BW +: BW];
  assign b2 = dsp_beat[2*BW +: BW];

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= '0;
    else        ready_q <= ready;
  end

  p_core_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[0] && b0 != BW'(CB - 1)) |=>
      (dsp_vld[0] && b0 == BW'($past(b0) + 1'b1) && $stable(w0)));

  p_lsu_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[1] && b1 != BW'(CB - 1)) |=>
      (dsp_vld[1] && b1 == BW'($past(b1) + 1'b1) && $stable(w1)));

  p_sfu_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[2] && b2 != BW'(SB - 1)) |=>
      (dsp_vld[2] && b2 == BW'($past(b2) + 1'b1) && $stable(w2)));

  p_sfu_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[2] && b2 == BW'(SB - 1)) |=> (!dsp_vld[2] || b2 == '0));

  p_split_01_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[0] && b0 == '0 && dsp_vld[1] && b1 == '0) |-> (w0[0] != w1[0]));

  p_split_02_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[0] && b0 == '0 && dsp_vld[2] && b2 == '0) |-> (w0[0] != w2[0]));

  p_split_12_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld[1] && b1 == '0 && dsp_vld[2] && b2 == '0) |-> (w1[0] != w2[0]));

  p_start_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!(dsp_vld[0] && b0 == '0) || ready_q[w0]) &&
     (!(dsp_vld[1] && b1 == '0) || ready_q[w1]) &&
     (!(dsp_vld[2] && b2 == '0) || ready_q[w2])));
endmodule

bind warp_issue warp_issue_chk #(
  .NW(NW), .IW(IW), .BW(BW), .CB(WARP / CLANES), .SB(WARP / SLANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dsp_vld(dsp_vld), .dsp_wid(dsp_wid),
  .dsp_beat(dsp_beat), .ready(ready)
);

// File: tb/warp_issue_tb.sv
`timescale 1ns/1ps
module warp_issue_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wake, stall;
  logic [15:0] cls;
  logic [2:0]  dsp_vld;
  logic [8:0]  dsp_wid, dsp_beat;
  logic [47:0] dsp_mask;
  int checks = 0;
  int errors = 0;

  warp_issue u_dut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .stall(stall), .cls(cls),
    .dsp_vld(dsp_vld), .dsp_wid(dsp_wid), .dsp_beat(dsp_beat),
    .dsp_mask(dsp_mask)
  );

  always #5 clk = ~clk;

  // {warp[2:0], class[1:0]}
  localparam logic [4:0] VEC [6] = '{
    {3'd0, 2'd0}, {3'd1, 2'd1}, {3'd2, 2'd2},
    {3'd5, 2'd0}, {3'd6, 2'd1}, {3'd3, 2'd2}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setcls(int w, logic [1:0] c);
    cls[2*w +: 2] = c;
  endtask

  task automatic chkg(int g, bit v, int w, int b, string tag);
    logic        gv;
    logic [2:0]  gw, gb;
    logic [15:0] gm, em;
    bit bad;
    gv = dsp_vld[g];
    gw = dsp_wid[3*g +: 3];
    gb = dsp_beat[3*g +: 3];
    gm = dsp_mask[16*g +: 16];
    em = (g == 2) ? 16'h000F : 16'hFFFF;
    bad = v ? (gv !== 1'b1 || gw !== 3'(w) || gb !== 3'(b) || gm !== em)
            : (gv !== 1'b0);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s grp%0d got v%0d w%0d b%0d m%h exp v%0d w%0d b%0d m%h",
               tag, g, gv, gw, gb, gm, v, w, b, v ? em : 16'h0);
    end
  endtask

  task automatic idle(string tag);
    for (int g = 0; g < 3; g++) chkg(g, 1'b0, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wake = '0;
    stall = '0;
    cls = '0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    idle("R1 after reset");
    for (int i = 0; i < 3; i++) begin
      step();
      idle("R1 no wake");
    end

    // table: single warp per entry
    for (int i = 0; i < 6; i++) begin
      int w, c, nb;
      w = int'(VEC[i][4:2]);
      c = int'(VEC[i][1:0]);
      nb = (c == 2) ? 8 : 2;
      setcls(w, 2'(c));
      wake = 8'(1 << w);
      step();
      wake = '0;
      step();
      for (int b = 0; b < nb; b++) begin
        chkg(c, 1'b1, w, b, (b == 0) ? "R2 start" : (c == 2) ? "R4 beat" : "R3 beat");
        step();
      end
      idle("R3/R4 end");
      step();
      idle("R5 no reissue");
    end

    // R7: both schedulers together
    setcls(0, 2'd0);
    setcls(1, 2'd1);
    wake = 8'b0000_0011;
    step();
    wake = '0;
    step();
    chkg(0, 1'b1, 0, 0, "R7 even");
    chkg(1, 1'b1, 1, 0, "R7 odd");
    step();
    chkg(0, 1'b1, 0, 1, "R7 even");
    chkg(1, 1'b1, 1, 1, "R7 odd");
    step();
    idle("R7 end");

    // R8: same group conflict
    setcls(2, 2'd0);
    setcls(3, 2'd0);
    wake = 8'b0000_1100;
    step();
    wake = '0;
    step();
    chkg(0, 1'b1, 2, 0, "R8 even wins");
    step();
    chkg(0, 1'b1, 2, 1, "R8 even");
    step();
    chkg(0, 1'b1, 3, 0, "R8 odd later");
    step();
    chkg(0, 1'b1, 3, 1, "R8 odd");
    step();
    idle("R8 end");

    // R10: round robin
    do_reset();
    wake = 8'b0001_0000;
    step();
    wake = '0;
    step();
    chkg(0, 1'b1, 4, 0, "R10 first");
    step();
    step();
    idle("R10 gap");
    wake = 8'b0101_0101;
    step();
    wake = '0;
    step();
    chkg(0, 1'b1, 6, 0, "R10 order");
    step();
    step();
    chkg(0, 1'b1, 0, 0, "R10 order");
    step();
    step();
    chkg(0, 1'b1, 2, 0, "R10 order");
    step();
    step();
    chkg(0, 1'b1, 4, 0, "R10 order");
    step();
    step();
    idle("R10 end");

    // R9 / R6: busy group skip, stall
    setcls(1, 2'd2);
    setcls(0, 2'd2);
    setcls(2, 2'd0);
    wake = 8'b0000_0010;
    step();
    wake = 8'b0000_0101;
    step();
    wake = '0;
    chkg(2, 1'b1, 1, 0, "R9 sfu");
    step();
    chkg(2, 1'b1, 1, 1, "R9 sfu busy");
    chkg(0, 1'b1, 2, 0, "R9 skip to free group");
    stall = 8'b0000_0001;
    step();
    stall = '0;
    repeat (6) step();
    idle("R6 stalled not issued");
    wake = 8'b0000_0001;
    step();
    wake = '0;
    step();
    chkg(2, 1'b1, 0, 0, "R6 wake again");
    repeat (8) step();
    idle("R6 end");

    // R11: class 3 ineligible
    setcls(4, 2'd3);
    wake = 8'b0001_0000;
    step();
    wake = '0;
    for (int i = 0; i < 3; i++) begin
      step();
      idle("R11 class3");
    end
    setcls(4, 2'd0);
    step();
    chkg(0, 1'b1, 4, 0, "R11 valid class");
    step();
    step();
    idle("R11 end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule